// File: doc/BRIEF.md
# Write-once fuse array controller

This block models a one-time-programmable fuse array behind a small register interface. Software sets three power/enable controls, chooses a word and a bit position, selects the data value for that bit and then pulses a program strobe. Each fuse bit can be programmed exactly once. A second array of tracking bits, one per fuse bit, records which bits have already been programmed and blocks any further attempt on them. A blocked attempt raises a sticky error flag that software clears by writing a one to it.

Reading the fuse word is allowed only while all three enables are on. Otherwise the read returns a fixed 0xFF pattern. On reset the array is cleared, a configured serial number and its bitwise complement are placed in two fixed neighbouring words, and the whole tracking map is cleared. The register window is 4 KiB with word-aligned offsets. The stored word address is 12 bits wide. The array depth is a parameter, and the array is indexed by the low bits of that address.

Top module: `fuse_otp_ctrl`

## Requirements
- R1: A read of the fuse data register (offset 0x20) returns the addressed word only when bit 0 is set in the chip-enable (0x00), standby-enable (0x04) and trim-enable (0x08) registers together; in every other combination it returns 0x000000FF.
- R2: The enable registers keep only bit 0 of a write and read back as that bit. The word-address register (0x0C) keeps the low 12 bits and reads back as those bits. The array is indexed by the low FUSE_AW bits of that address.
- R3: Writing the program register (0x1C) with bit 0 = 1 while the redundancy register is 0 sets bit position [bit index register 0x10] of the selected word to bit 0 of the data-in register (0x14): a one sets the bit and a zero clears it. A read issued on the next cycle shows the new word.
- R4: A write to the program register with bit 0 = 0 changes neither the array nor the tracking map.
- R5: A program strobe aimed at a bit whose tracking bit is already set leaves the word unchanged and sets the error flag.
- R6: The error flag is bit 0 of the status register (0x24). It stays set until a write to the status register with bit 0 = 1 clears it. A write with bit 0 = 0 leaves it set.
- R7: While the redundancy register (0x18, bit 0) is 1, a program strobe changes neither the array nor the tracking map.
- R8: After reset, word SERIAL_ADDR holds SERIAL, word SERIAL_ADDR+1 holds ~SERIAL, every other word is zero, all control registers read zero and the error flag is clear.
- R9: Reset clears the whole tracking map, so a bit that was programmed before the reset can be programmed again after it.
- R10: Reads of unmapped or misaligned offsets return zero. Writes to them, and writes to the data register, have no effect.
- R11: Read data and rvalid_o are registered. They appear on the clock edge after the one that samples the read request, and rvalid_o is low after any cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the register window |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
A register write, including a program strobe, takes effect on the same rising edge that samples it. The result of a read appears on the following edge. The bench drives every access at a falling edge, holds it across exactly one rising edge and samples read data at the next falling edge. Because of this, a read that follows a program strobe always observes the updated word and status. Near-exhaustive sweeps cover all eight enable combinations and every bit position of a word, and a reference array with its own tracking map in the bench supplies every expected value.

// File: rtl/fuse_otp_pkg.sv
package fuse_otp_pkg;
  localparam int unsigned OFF_W = 12;

  typedef enum logic [3:0] {
    SEL_CE, SEL_SB, SEL_TR, SEL_PA, SEL_BIT, SEL_DIN,
    SEL_RED, SEL_PROG, SEL_DATA, SEL_STAT, SEL_NONE
  } reg_sel_e;

  localparam logic [OFF_W-1:0] OFF_CE   = 12'h000;
  localparam logic [OFF_W-1:0] OFF_SB   = 12'h004;
  localparam logic [OFF_W-1:0] OFF_TR   = 12'h008;
  localparam logic [OFF_W-1:0] OFF_PA   = 12'h00C;
  localparam logic [OFF_W-1:0] OFF_BIT  = 12'h010;
  localparam logic [OFF_W-1:0] OFF_DIN  = 12'h014;
  localparam logic [OFF_W-1:0] OFF_RED  = 12'h018;
  localparam logic [OFF_W-1:0] OFF_PROG = 12'h01C;
  localparam logic [OFF_W-1:0] OFF_DATA = 12'h020;
  localparam logic [OFF_W-1:0] OFF_STAT = 12'h024;

  function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] a);
    unique case (a)
      OFF_CE:   return SEL_CE;
      OFF_SB:   return SEL_SB;
      OFF_TR:   return SEL_TR;
      OFF_PA:   return SEL_PA;
      OFF_BIT:  return SEL_BIT;
      OFF_DIN:  return SEL_DIN;
      OFF_RED:  return SEL_RED;
      OFF_PROG: return SEL_PROG;
      OFF_DATA: return SEL_DATA;
      OFF_STAT: return SEL_STAT;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fuse_otp_regs.sv
module fuse_otp_regs
  import fuse_otp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FUSE_AW = 8,
  parameter int unsigned PA_W    = 12,
  localparam int unsigned BI_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] fuse_word_i,
  input  logic              reject_i,
  output logic [FUSE_AW-1:0] idx_o,
  output logic [BI_W-1:0]   bit_o,
  output logic              din_o,
  output logic              prog_o,
  output logic              en_all_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam logic [DATA_W-1:0] RD_BLOCKED = DATA_W'(8'hFF);

  logic            ce_q, sb_q, tr_q, din_q, red_q, prog_q, err_q;
  logic [PA_W-1:0] pa_q;
  logic [BI_W-1:0] bit_q;
  logic [DATA_W-1:0] rd_mux;
  reg_sel_e        sel;
  logic            wr, rd;
  logic            unused_wdata;

  assign sel = decode_off(addr_i);
  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;
  assign unused_wdata = ^wdata_i[DATA_W-1:PA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= 1'b0; sb_q <= 1'b0; tr_q <= 1'b0;
      din_q <= 1'b0; red_q <= 1'b0; prog_q <= 1'b0;
      pa_q <= '0; bit_q <= '0; err_q <= 1'b0;
    end else begin
      if (wr) begin
        unique case (sel)
          SEL_CE:   ce_q   <= wdata_i[0];
          SEL_SB:   sb_q   <= wdata_i[0];
          SEL_TR:   tr_q   <= wdata_i[0];
          SEL_PA:   pa_q   <= wdata_i[PA_W-1:0];
          SEL_BIT:  bit_q  <= wdata_i[BI_W-1:0];
          SEL_DIN:  din_q  <= wdata_i[0];
          SEL_RED:  red_q  <= wdata_i[0];
          SEL_PROG: prog_q <= wdata_i[0];
          SEL_STAT: if (wdata_i[0]) err_q <= 1'b0;
          default: ;
        endcase
      end
      // a rejected program wins over any clear in the same cycle
      if (reject_i) err_q <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CE:   rd_mux[0] = ce_q;
      SEL_SB:   rd_mux[0] = sb_q;
      SEL_TR:   rd_mux[0] = tr_q;
      SEL_PA:   rd_mux[PA_W-1:0] = pa_q;
      SEL_BIT:  rd_mux[BI_W-1:0] = bit_q;
      SEL_DIN:  rd_mux[0] = din_q;
      SEL_RED:  rd_mux[0] = red_q;
      SEL_PROG: rd_mux[0] = prog_q;
      SEL_DATA: rd_mux = en_all_o ? fuse_word_i : RD_BLOCKED;
      SEL_STAT: rd_mux[0] = err_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

  assign en_all_o = ce_q && sb_q && tr_q;
  assign idx_o    = pa_q[FUSE_AW-1:0];
  assign bit_o    = bit_q;
  assign din_o    = din_q;
  assign err_o    = err_q;
  assign prog_o   = wr && (sel == SEL_PROG) && wdata_i[0] && !red_q;
endmodule

// File: rtl/fuse_otp_store.sv
module fuse_otp_store #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned FUSE_AW     = 8,
  parameter logic [DATA_W-1:0] SERIAL = '0,
  parameter int unsigned SERIAL_ADDR = 'hFC,
  localparam int unsigned DEPTH      = 1 << FUSE_AW,
  localparam int unsigned BI_W       = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FUSE_AW-1:0] idx_i,
  input  logic [BI_W-1:0]    bit_i,
  input  logic               din_i,
  input  logic               prog_i,
  output logic [DATA_W-1:0]  word_o,
  output logic               reject_o
);
  logic [DATA_W-1:0] word_rd [DEPTH];
  logic [DATA_W-1:0] wo_rd   [DEPTH];
  logic              locked;

  assign locked   = wo_rd[idx_i][bit_i];
  assign reject_o = prog_i && locked;
  assign word_o   = word_rd[idx_i];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [DATA_W-1:0] INIT =
      (w == SERIAL_ADDR)     ? SERIAL :
      (w == SERIAL_ADDR + 1) ? ~SERIAL : '0;
    logic [DATA_W-1:0] word_q, wo_q;
    logic              hit;

    assign hit = prog_i && !locked && (idx_i == FUSE_AW'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= INIT;
        wo_q   <= '0;
      end else if (hit) begin
        word_q[bit_i] <= din_i;
        wo_q[bit_i]   <= 1'b1;
      end
    end

    assign word_rd[w] = word_q;
    assign wo_rd[w]   = wo_q;
  end
endmodule

// File: rtl/fuse_otp_ctrl.sv
module fuse_otp_ctrl
  import fuse_otp_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned FUSE_AW     = 8,
  parameter logic [DATA_W-1:0] SERIAL = 32'hA5C3_0F96,
  parameter int unsigned SERIAL_ADDR = 'hFC,
  localparam int unsigned BI_W       = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [FUSE_AW-1:0] idx;
  logic [BI_W-1:0]    bit_sel;
  logic               din, prog, reject, en_all, err;
  logic [DATA_W-1:0]  fuse_word;

  fuse_otp_regs #(.DATA_W(DATA_W), .FUSE_AW(FUSE_AW), .PA_W(12)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .fuse_word_i(fuse_word), .reject_i(reject),
    .idx_o(idx), .bit_o(bit_sel), .din_o(din), .prog_o(prog),
    .en_all_o(en_all), .err_o(err), .rdata_o, .rvalid_o
  );

  fuse_otp_store #(.DATA_W(DATA_W), .FUSE_AW(FUSE_AW), .SERIAL(SERIAL),
                   .SERIAL_ADDR(SERIAL_ADDR)) u_store (
    .clk_i, .rst_ni, .idx_i(idx), .bit_i(bit_sel), .din_i(din),
    .prog_i(prog), .word_o(fuse_word), .reject_o(reject)
  );
endmodule

// File: rtl/fuse_otp_chk.sv
module fuse_otp_chk
  import fuse_otp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [11:0]       addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              en_all_i,
  input logic              reject_i,
  input logic              err_i
);
  logic stat_clr;
  assign stat_clr = req_i && we_i && (addr_i == OFF_STAT) && wdata_i[0];

  a_r1_gated_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFF_DATA && !en_all_i) |=> (rdata_o == DATA_W'(8'hFF)));

  a_r5_reject_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_i |=> err_i);

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !stat_clr) |=> err_i);

  a_r6_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr && !reject_i) |=> !err_i);

  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && decode_off(addr_i) == SEL_NONE) |=> (rdata_o == '0));

  a_r11_rvalid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  a_r11_rvalid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
endmodule

bind fuse_otp_ctrl fuse_otp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
  .en_all_i(en_all), .reject_i(reject), .err_i(err)
);

// File: tb/tb_fuse_otp_ctrl.sv
module tb_fuse_otp_ctrl;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [31:0] SER = 32'hA5C3_0F96;
  localparam int unsigned SADDR = 'hFC;
  localparam logic [31:0] PAT = 32'h6B2D_93C5;

  localparam logic [11:0] A_CE = 12'h000, A_SB = 12'h004, A_TR = 12'h008,
    A_PA = 12'h00C, A_BIT = 12'h010, A_DIN = 12'h014, A_RED = 12'h018,
    A_PROG = 12'h01C, A_DATA = 12'h020, A_STAT = 12'h024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] mf [DEPTH];
  logic [31:0] mw [DEPTH];
  logic m_err, m_red;

  always #5 clk = ~clk;

  fuse_otp_ctrl #(.DATA_W(DW), .FUSE_AW(AW), .SERIAL(SER), .SERIAL_ADDR(SADDR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      mf[i] = (i == SADDR) ? SER : ((i == SADDR + 1) ? ~SER : 32'h0);
      mw[i] = '0;
    end
    m_err = 1'b0;
    m_red = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_word(input int w, output logic [31:0] d);
    wr(A_PA, 32'(w));
    rd(A_DATA, d);
  endtask

  task automatic prog(input int w, input int b, input logic din);
    wr(A_PA, 32'(w));
    wr(A_BIT, 32'(b));
    wr(A_DIN, {31'b0, din});
    wr(A_PROG, 32'h1);
    if (!m_red) begin
      if (mw[w][b]) m_err = 1'b1;
      else begin
        mf[w][b] = din;
        mw[w][b] = 1'b1;
      end
    end
  endtask

  task automatic enables(input logic [2:0] c);
    wr(A_CE, {31'b0, c[0]});
    wr(A_SB, {31'b0, c[1]});
    wr(A_TR, {31'b0, c[2]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    model_reset();
    do_reset();

    // R8 reset state
    rd(A_CE, d);   chk("R8 ce reset", d, 32'h0);
    rd(A_PA, d);   chk("R8 addr reset", d, 32'h0);
    rd(A_STAT, d); chk("R8 err reset", d, 32'h0);
    enables(3'b111);
    rd_word(SADDR, d);     chk("R8 serial word", d, SER);
    rd_word(SADDR + 1, d); chk("R8 serial complement", d, ~SER);
    rd_word(16, d);        chk("R8 other word zero", d, 32'h0);

    // R1 all enable combinations
    for (int c = 0; c < 8; c++) begin
      enables(3'(c));
      rd_word(SADDR, d);
      chk($sformatf("R1 gate combo %0d", c), d, (c == 7) ? SER : 32'hFF);
    end

    // R2 bit 0 only, address width and aliasing
    wr(A_CE, 32'hFFFF_FFFE);
    rd(A_CE, d);   chk("R2 ce keeps bit0", d, 32'h0);
    rd(A_DATA, d); chk("R2 ce bit0 clear blocks", d, 32'hFF);
    wr(A_CE, 32'h3);
    rd(A_CE, d);   chk("R2 ce readback", d, 32'h1);
    wr(A_PA, 32'hFFFF_F1FD);
    rd(A_PA, d);   chk("R2 addr 12 bits", d, 32'h1FD);
    rd(A_DATA, d); chk("R2 addr alias low bits", d, ~SER);

    // R11 read timing
    @(negedge clk); req = 1'b1; we = 1'b0; addr = A_CE;
    @(negedge clk); req = 1'b0;
    chk("R11 rvalid after read", {31'b0, rvalid}, 32'h1);
    @(negedge clk);
    chk("R11 rvalid drops", {31'b0, rvalid}, 32'h0);

    // R3 sweep every bit of word 5
    for (int b = 0; b < 32; b++) begin
      prog(5, b, PAT[b]);
      rd_word(5, d);
      chk($sformatf("R3 word5 bit %0d", b), d, mf[5]);
    end
    // R3 clear a set serial bit
    prog(SADDR, 1, 1'b0);
    rd_word(SADDR, d); chk("R3 clear bit", d, mf[SADDR]);
    chk("R3 clear value", mf[SADDR], SER & ~32'h2);
    // R3 one bit in each of several words
    for (int w = 16; w < 32; w++) begin
      prog(w, (w * 7) % 32, 1'b1);
      rd_word(w, d);
      chk($sformatf("R3 word %0d", w), d, mf[w]);
    end
    rd(A_STAT, d); chk("R3 no error", d, 32'h0);

    // R4 strobe with bit0 = 0
    wr(A_PA, 7); wr(A_BIT, 3); wr(A_DIN, 1); wr(A_PROG, 32'h2);
    rd(A_DATA, d); chk("R4 no program", d, 32'h0);
    prog(7, 3, 1'b1);
    rd_word(7, d); chk("R4 bit still free", d, 32'h8);

    // R5 reprogram rejected
    prog(5, 0, ~PAT[0]);
    rd_word(5, d); chk("R5 word unchanged", d, PAT);
    rd(A_STAT, d); chk("R5 error set", d, {31'b0, m_err});

    // R6 sticky and write-one-to-clear
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R6 write zero keeps", d, 32'h1);
    wr(A_STAT, 32'h1); m_err = 1'b0;
    rd(A_STAT, d); chk("R6 write one clears", d, 32'h0);

    // R7 redundancy select blocks
    wr(A_RED, 32'h1); m_red = 1'b1;
    prog(9, 4, 1'b1);
    rd_word(9, d); chk("R7 no change", d, 32'h0);
    rd(A_STAT, d); chk("R7 no error", d, 32'h0);
    wr(A_RED, 32'h0); m_red = 1'b0;
    prog(9, 4, 1'b1);
    rd_word(9, d); chk("R7 map untouched", d, 32'h10);
    rd(A_STAT, d); chk("R7 later program ok", d, 32'h0);

    // R10 unmapped and read-only
    rd(12'h040, d); chk("R10 unmapped read", d, 32'h0);
    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h040, d); chk("R10 unmapped write", d, 32'h0);
    rd(12'h001, d); chk("R10 misaligned read", d, 32'h0);
    wr(12'h001, 32'h0);
    rd(A_CE, d);   chk("R10 misaligned write ignored", d, 32'h1);
    wr(A_PA, 9); wr(A_DATA, 32'hFFFF_FFFF);
    rd(A_DATA, d); chk("R10 data read only", d, 32'h10);

    // R9 reset clears the map and reloads
    do_reset();
    rd(A_TR, d);   chk("R8 trim after reset", d, 32'h0);
    enables(3'b111);
    rd_word(SADDR, d); chk("R8 serial reloaded", d, SER);
    rd_word(9, d);     chk("R8 word zeroed", d, 32'h0);
    prog(5, 0, 1'b1);
    rd_word(5, d);     chk("R9 reprogram after reset", d, 32'h1);
    rd(A_STAT, d);     chk("R9 no error", d, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule